// File: doc/BRIEF.md
# Banked Memory Chip-Select Decoder

This block is a purely combinational address decoder that places two interchangeable memory banks at one window of a processor's address map. The two most significant address bits pick one quarter of the map. Only the second quarter (top bits equal to 2'b01) is claimed by the banks. Both banks answer to that same window. A single bank-select bit, held in a register outside this block, decides which bank actually receives its chip enable.

Beside the two bank enables, the block drives 32 active-low row-select lines. They are produced by a two-level decoder tree. A 2-to-4 stage, gated by the qualified window hit, drives the active-low enables of four 3-to-8 stages. All outputs idle at logic 1. A master enable, also active-low, silences every output when it is high.

The block has no clock and no state. A change on the bank-select bit or the address is seen on the outputs in the same decode.

Top module: `bank_cs_dec`

## Requirements
- R1: Bank and row outputs may be asserted only when addr_i[15:14] equals 2'b01, which is the second quarter of the map (addresses 0x4000 to 0x7FFF).
- R2: With en_ni low and the address inside the window, bank_sel_i = 0 gives bank_ce_no = 2'b10 (bank 0 low), and bank_sel_i = 1 gives bank_ce_no = 2'b01 (bank 1 low).
- R3: With the address outside the window, bank_ce_no is 2'b11 and row_sel_no is all ones, whatever bank_sel_i is.
- R4: With en_ni high, bank_ce_no is 2'b11 and row_sel_no is all ones, for any address and bank_sel_i.
- R5: With en_ni low and the address inside the window, exactly row_sel_no[k] is low, where k = addr_i[13:9]. Bits [13:12] pick the 3-to-8 group and bits [11:9] pick the line within the group. Every other row line is high.
- R6: At no time is more than one bank enable low, and at no time is more than one row line low.
- R7: The block holds no state. Toggling bank_sel_i with the address held fixed moves the bank enable in the same decode and leaves row_sel_no unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 16 | Processor address bus |
| en_ni | input | 1 | Master enable, active-low |
| bank_sel_i | input | 1 | Bank choice from the external bank register (0 = bank 0) |
| bank_ce_no | output | 2 | Chip enables, active-low, bit b for bank b |
| row_sel_no | output | 32 | Row-select lines, active-low |

## Verification
A fixed table exercises the edges of the window (0x3FFF, 0x4000, 0x7FFF, 0x8000) and the other quarters. It also covers addresses whose row index falls in different 3-to-8 groups and at different positions inside a group, which separates a wrong window compare from a wrong bit slice or a mis-wired group. Table rows with the master enable high confirm that no address can leak through. The bench then sweeps every address with both bank values against an independent model, and checks at each point that at most one bank enable and at most one row line is low. A directed toggle of the bank bit at a fixed address shows that the bank enable follows it at once and that the row lines do not react.

// File: rtl/bank_cs_dec_pkg.sv
package bank_cs_dec_pkg;
  localparam int unsigned ADDR_W_DEF  = 16;
  localparam int unsigned WIN_W_DEF   = 2;
  localparam int unsigned WIN_HIT_DEF = 1;
  localparam int unsigned GRP_W_DEF   = 2;
  localparam int unsigned SUB_W_DEF   = 3;
  localparam int unsigned BANKS       = 2;
endpackage

// File: rtl/dec_nl.sv
module dec_nl #(
  parameter int unsigned IN_W = 2,
  localparam int unsigned OUT_N = 1 << IN_W
) (
  input  logic [IN_W-1:0]  sel_i,
  input  logic             en_ni,
  output logic [OUT_N-1:0] y_no
);
  always_comb begin
    y_no = '1;
    if (!en_ni) y_no[sel_i] = 1'b0;
  end

  always_comb begin
    if (!$isunknown({sel_i, en_ni})) begin
      // R6
      one_low_chk: assert ($onehot0(~y_no))
        else $error("decoder drives more than one line low");
    end
  end
endmodule

// File: rtl/win_qual.sv
module win_qual #(
  parameter int unsigned WIN_W   = 2,
  parameter int unsigned WIN_HIT = 1
) (
  input  logic [WIN_W-1:0] top_i,
  input  logic             en_ni,
  output logic             hit_no
);
  always_comb hit_no = en_ni | (top_i != WIN_W'(WIN_HIT));
endmodule

// File: rtl/row_tree.sv
module row_tree #(
  parameter int unsigned GRP_W = 2,
  parameter int unsigned SUB_W = 3,
  localparam int unsigned GRP_N = 1 << GRP_W,
  localparam int unsigned SUB_N = 1 << SUB_W,
  localparam int unsigned ROW_N = GRP_N * SUB_N
) (
  input  logic [GRP_W+SUB_W-1:0] idx_i,
  input  logic                   en_ni,
  output logic [ROW_N-1:0]       row_no
);
  logic [GRP_N-1:0] grp_en_n;

  dec_nl #(.IN_W(GRP_W)) grp_dec_i (
    .sel_i (idx_i[GRP_W+SUB_W-1 -: GRP_W]),
    .en_ni (en_ni),
    .y_no  (grp_en_n)
  );

  for (genvar g = 0; g < GRP_N; g++) begin : g_leaf
    dec_nl #(.IN_W(SUB_W)) leaf_dec_i (
      .sel_i (idx_i[SUB_W-1:0]),
      .en_ni (grp_en_n[g]),
      .y_no  (row_no[g*SUB_N +: SUB_N])
    );
  end

  always_comb begin
    if (!$isunknown({idx_i, en_ni})) begin
      // R5: an active leaf output must sit in the group the upper stage enabled
      leaf_group_chk: assert (&row_no || !grp_en_n[idx_i[GRP_W+SUB_W-1 -: GRP_W]])
        else $error("row low outside the enabled group");
    end
  end
endmodule

// File: rtl/bank_cs_dec.sv
module bank_cs_dec
  import bank_cs_dec_pkg::*;
#(
  parameter int unsigned ADDR_W  = ADDR_W_DEF,
  parameter int unsigned WIN_W   = WIN_W_DEF,
  parameter int unsigned WIN_HIT = WIN_HIT_DEF,
  parameter int unsigned GRP_W   = GRP_W_DEF,
  parameter int unsigned SUB_W   = SUB_W_DEF,
  localparam int unsigned IDX_W  = GRP_W + SUB_W,
  localparam int unsigned ROW_N  = 1 << IDX_W,
  localparam int unsigned LOW_W  = ADDR_W - WIN_W - IDX_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_ni,
  input  logic              bank_sel_i,
  output logic [BANKS-1:0]  bank_ce_no,
  output logic [ROW_N-1:0]  row_sel_no
);
  logic hit_n;
  logic unused_low;

  assign unused_low = ^addr_i[LOW_W-1:0];

  win_qual #(.WIN_W(WIN_W), .WIN_HIT(WIN_HIT)) win_i (
    .top_i  (addr_i[ADDR_W-1 -: WIN_W]),
    .en_ni  (en_ni),
    .hit_no (hit_n)
  );

  // bank steering is a 1-to-2 decoder gated by the window hit
  dec_nl #(.IN_W(1)) bank_dec_i (
    .sel_i (bank_sel_i),
    .en_ni (hit_n),
    .y_no  (bank_ce_no)
  );

  row_tree #(.GRP_W(GRP_W), .SUB_W(SUB_W)) rows_i (
    .idx_i  (addr_i[ADDR_W-WIN_W-1 -: IDX_W]),
    .en_ni  (hit_n),
    .row_no (row_sel_no)
  );

  always_comb begin
    if (!$isunknown({addr_i, en_ni, bank_sel_i})) begin
      // R4
      master_off_chk: assert (!en_ni || (&bank_ce_no && &row_sel_no))
        else $error("output active with master enable high");
      // R1 R3
      window_only_chk: assert ((addr_i[ADDR_W-1 -: WIN_W] == WIN_W'(WIN_HIT)) ||
                               (&bank_ce_no && &row_sel_no))
        else $error("output active outside window");
      // R6
      bank_excl_chk: assert ($onehot0(~bank_ce_no))
        else $error("both banks enabled");
      // R5: a row line is low exactly when some bank is enabled
      row_bank_pair_chk: assert ((&row_sel_no) == (&bank_ce_no))
        else $error("row and bank enables disagree");
    end
  end
endmodule

// File: tb/bank_cs_dec_tb_top.sv
module bank_cs_dec_tb_top;
  logic        clk = 1'b0;
  logic [15:0] addr;
  logic        en_n;
  logic        sel;
  logic [1:0]  bank_n;
  logic [31:0] row_n;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  bank_cs_dec dut_i (
    .addr_i     (addr),
    .en_ni      (en_n),
    .bank_sel_i (sel),
    .bank_ce_no (bank_n),
    .row_sel_no (row_n)
  );

  // {addr, en_n, sel, expected bank_ce_no, expected row index (63 = none)}
  localparam int NV = 14;
  localparam logic [25:0] VEC [NV] = '{
    {16'h4000, 1'b0, 1'b0, 2'b10, 6'd0},
    {16'h4000, 1'b0, 1'b1, 2'b01, 6'd0},
    {16'h7FFF, 1'b0, 1'b0, 2'b10, 6'd31},
    {16'h7FFF, 1'b0, 1'b1, 2'b01, 6'd31},
    {16'h3FFF, 1'b0, 1'b0, 2'b11, 6'd63},
    {16'h8000, 1'b0, 1'b1, 2'b11, 6'd63},
    {16'hC000, 1'b0, 1'b0, 2'b11, 6'd63},
    {16'h0000, 1'b0, 1'b1, 2'b11, 6'd63},
    {16'h4000, 1'b1, 1'b0, 2'b11, 6'd63},
    {16'h5A00, 1'b0, 1'b0, 2'b10, 6'd13},
    {16'h6200, 1'b0, 1'b1, 2'b01, 6'd17},
    {16'h5FFF, 1'b1, 1'b1, 2'b11, 6'd63},
    {16'h4E00, 1'b0, 1'b1, 2'b01, 6'd7},
    {16'h5000, 1'b0, 1'b0, 2'b10, 6'd8}
  };

  function automatic logic [31:0] row_of(input logic [5:0] idx);
    return (idx == 6'd63) ? 32'hFFFF_FFFF : ~(32'd1 << idx[4:0]);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s addr=%h en_n=%b sel=%b got=%h exp=%h", req, addr, en_n, sel, got, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic e, input logic s);
    addr = a; en_n = e; sel = s;
    #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // idle state with master enable high (R4)
    drive(16'h4000, 1'b1, 1'b0);
    chk("R4 idle bank", {30'd0, bank_n}, 32'h3);
    chk("R4 idle row", row_n, 32'hFFFF_FFFF);

    // table: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][25:10], VEC[i][9], VEC[i][8]);
      chk("R1/R2/R3 bank", {30'd0, bank_n}, {30'd0, VEC[i][7:6]});
      chk("R5 row", row_n, row_of(VEC[i][5:0]));
    end

    // R7: toggle bank bit at fixed address
    drive(16'h6A00, 1'b0, 1'b0);
    chk("R7 bank before", {30'd0, bank_n}, 32'h2);
    chk("R7 row before", row_n, ~(32'd1 << 21));
    sel = 1'b1; #2;
    chk("R7 bank after", {30'd0, bank_n}, 32'h1);
    chk("R7 row after", row_n, ~(32'd1 << 21));
    sel = 1'b0; #2;
    chk("R7 bank back", {30'd0, bank_n}, 32'h2);

    // R4 master enable over an in-window sweep point
    drive(16'h7000, 1'b1, 1'b1);
    chk("R4 bank", {30'd0, bank_n}, 32'h3);
    chk("R4 row", row_n, 32'hFFFF_FFFF);

    // full sweep against model, plus R6 invariant
    for (int a = 0; a < 65536; a++) begin
      for (int s = 0; s < 2; s++) begin
        logic [15:0] av;
        logic        in_win;
        logic [1:0]  eb;
        logic [31:0] er;
        av = 16'(a);
        in_win = (av[15:14] == 2'b01);
        eb = !in_win ? 2'b11 : (s == 1 ? 2'b01 : 2'b10);
        er = in_win ? ~(32'd1 << av[13:9]) : 32'hFFFF_FFFF;
        drive(av, 1'b0, s[0]);
        chk("R1/R2/R3 sweep bank", {30'd0, bank_n}, {30'd0, eb});
        chk("R5 sweep row", row_n, er);
        chk("R6 excl", {30'd0, ($countones(~bank_n) > 1), ($countones(~row_n) > 1)}, 32'd0);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule